// File: doc/BRIEF.md
# Sub-block Interleaver Address Generator

This block produces the read order of one turbo rate-matching sub-block interleaver. A stream of D coded bits (payload plus four tail bits) is laid out, row by row, in a matrix of 32 columns. The row count is the smallest that holds the stream. Unused positions are padded at the front of the matrix. The columns are then reordered by a fixed permutation, and the matrix is read out column by column. For every output slot the block emits the original bit index and a flag that marks the slot as null, so a downstream reader can skip it. Storing the bits themselves is left to the surrounding logic.

A start pulse loads the stream length, the number of filler bits at the head of the payload, and a stream selector: 0 systematic, 1 first parity, 2 or 3 second parity. From the next cycle, one slot per accepted handshake is offered on a valid/ready output. Filler bits count as null in the systematic and first-parity streams. The second-parity stream uses a read position shifted by one and ignores fillers. After the last of the 32·R slots, a one-cycle done pulse is given.

Top module: `sbi_addr_gen`

## Requirements
- R1: After reset, out_valid_o and done_o are 0.
- R2: For a loaded length D (1..MAX_LEN), the row count is R = ceil(D/32). Exactly 32·R slots are offered, with out_valid_o held high from the first slot until the last one is accepted, and done_o stays 0 during that time.
- R3: The first ND = 32·R − D matrix positions (position p = 32·row + column, row-major) are dummy positions and are flagged null in every stream.
- R4: The column permutation is the 5-bit bit reversal of the column number (0,16,8,24,4,...,31). Slot k reads column c = k div R and row r = k mod R. For selectors 0 and 1 it reads matrix position p = perm(c) + 32·r.
- R5: For selectors 2 and 3, slot k reads position p = (perm(c) + 32·r + 1) mod 32·R.
- R6: For selectors 0 and 1, positions ND to ND+F−1 (F = fill_i) are flagged null. For selectors 2 and 3, only the dummy positions are null.
- R7: A non-null slot carries out_index_o = p − ND. A null slot carries out_index_o = 0.
- R8: While out_valid_o is high and out_ready_i is low, the slot is held unchanged. Each cycle with both high advances by exactly one slot.
- R9: done_o is high for exactly one cycle, the cycle after the last slot is accepted, and out_valid_o is 0 in that cycle.
- R10: out_valid_o rises in the cycle after a start pulse given while idle. A start pulse while slots are still being offered is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load configuration and begin a sequence (idle only) |
| len_i | input | LEN_W | Stream length D, payload plus tail |
| fill_i | input | LEN_W | Number of filler bits at the head of the stream |
| sel_i | input | 2 | Stream selector: 0 systematic, 1 parity one, 2/3 parity two |
| out_valid_o | output | 1 | Slot is offered |
| out_ready_i | input | 1 | Consumer accepts the offered slot |
| out_index_o | output | LEN_W | Original bit index of the slot (0 when null) |
| out_null_o | output | 1 | Slot is a dummy or filler position |
| done_o | output | 1 | One-cycle pulse after the last slot is accepted |

## Verification
The first slot is due one clock after the start edge. Each following slot is due in the cycle after an accepting edge, and done is due in the cycle after the final accept. The bench drives ready and start on falling edges. It compares the offered slot at the same falling edge, before the edge that consumes it, so every comparison sees exactly the registered state after the previous edge. Length sweeps cover a single row, almost-all-dummy padding, fillers and the largest length, for every selector and under three ready patterns. A start injected mid-stream shows that the sequence continues unchanged.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int NCOL  = 32;
  localparam int COL_W = 5;

  typedef enum logic [1:0] {
    STRM_SYS   = 2'd0,
    STRM_PAR1  = 2'd1,
    STRM_PAR2  = 2'd2,
    STRM_PAR2B = 2'd3
  } strm_e;

  // column reorder: bit reversal of the column number
  function automatic int col_perm(input int c);
    int r;
    r = 0;
    for (int b = 0; b < COL_W; b++)
      if (((c >> b) & 1) != 0) r = r | (1 << (COL_W - 1 - b));
    return r;
  endfunction

  function automatic int row_count(input int len);
    return (len + NCOL - 1) / NCOL;
  endfunction

  // matrix position read by (column, row); shifted variant for parity two
  function automatic int slot_pos(input int col, input int row,
                                  input int rows, input logic shifted);
    int p;
    p = col_perm(col) + NCOL * row;
    if (shifted) begin
      p = p + 1;
      if (p >= NCOL * rows) p = p - NCOL * rows;
    end
    return p;
  endfunction
endpackage

// File: rtl/sbi_cfg.sv
module sbi_cfg
  import sbi_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] fill_i,
  input  logic [1:0]       sel_i,
  output logic [ROW_W-1:0] rows_o,
  output logic [LEN_W-1:0] nd_o,
  output logic [LEN_W-1:0] fill_o,
  output logic             p2_o
);
  int rows_n;

  always_comb rows_n = row_count(int'(len_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_o <= '0;
      nd_o   <= '0;
      fill_o <= '0;
      p2_o   <= 1'b0;
    end else if (load) begin
      rows_o <= ROW_W'(rows_n);
      nd_o   <= LEN_W'(NCOL * rows_n - int'(len_i));
      fill_o <= fill_i;
      p2_o   <= (strm_e'(sel_i) == STRM_PAR2) || (strm_e'(sel_i) == STRM_PAR2B);
    end
  end
endmodule

// File: rtl/sbi_seq.sv
module sbi_seq
  import sbi_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  input  logic [ROW_W-1:0] rows,
  output logic             active,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             load,
  output logic             last_accept,
  output logic             done
);
  logic accept;
  logic row_last;
  logic col_last;

  assign load        = start & ~active;
  assign accept      = active & ready;
  assign row_last    = (row == rows - ROW_W'(1));
  assign col_last    = (col == COL_W'(NCOL - 1));
  assign last_accept = accept & row_last & col_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
      col    <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_accept;
      if (load) begin
        active <= 1'b1;
        row    <= '0;
        col    <= '0;
      end else if (accept) begin
        if (row_last) begin
          row <= '0;
          col <= col + COL_W'(1);
          if (col_last) active <= 1'b0;
        end else begin
          row <= row + ROW_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sbi_map.sv
module sbi_map
  import sbi_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int ROW_W = 8
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] rows,
  input  logic [LEN_W-1:0] nd,
  input  logic [LEN_W-1:0] fill,
  input  logic             p2,
  output logic [LEN_W-1:0] idx,
  output logic             nul
);
  int pos;
  int rel;

  always_comb begin
    pos = slot_pos(int'(col), int'(row), int'(rows), p2);
    rel = pos - int'(nd);
    nul = (pos < int'(nd)) || (!p2 && (rel < int'(fill)));
    idx = nul ? '0 : LEN_W'(rel);
  end
endmodule

// File: rtl/sbi_addr_gen.sv
module sbi_addr_gen
  import sbi_pkg::*;
#(
  parameter int MAX_LEN = 6148,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int MAX_ROWS = (MAX_LEN + NCOL - 1) / NCOL,
  localparam int ROW_W    = $clog2(MAX_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] fill_i,
  input  logic [1:0]       sel_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [LEN_W-1:0] out_index_o,
  output logic             out_null_o,
  output logic             done_o
);
  logic [ROW_W-1:0] rows;
  logic [LEN_W-1:0] nd;
  logic [LEN_W-1:0] fill;
  logic             p2;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             load;
  logic             last_accept;

  sbi_cfg #(.LEN_W(LEN_W), .ROW_W(ROW_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .len_i(len_i), .fill_i(fill_i), .sel_i(sel_i),
    .rows_o(rows), .nd_o(nd), .fill_o(fill), .p2_o(p2)
  );

  sbi_seq #(.ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .ready(out_ready_i),
    .rows(rows), .active(out_valid_o), .row(row), .col(col),
    .load(load), .last_accept(last_accept), .done(done_o)
  );

  sbi_map #(.LEN_W(LEN_W), .ROW_W(ROW_W)) u_map (
    .row(row), .col(col), .rows(rows), .nd(nd), .fill(fill), .p2(p2),
    .idx(out_index_o), .nul(out_null_o)
  );
endmodule

// File: rtl/sbi_addr_gen_chk.sv
module sbi_addr_gen_chk #(
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [LEN_W-1:0] out_index_o,
  input logic             out_null_o,
  input logic             done_o,
  input logic             load,
  input logic             last_accept
);
  // R8
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_index_o) && $stable(out_null_o));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_accept |=> done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  null_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_null_o |-> out_index_o == '0);

  // R10
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid_o);

  // R2
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !last_accept |=> out_valid_o);
endmodule

bind sbi_addr_gen sbi_addr_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_index_o(out_index_o), .out_null_o(out_null_o), .done_o(done_o),
  .load(load), .last_accept(last_accept)
);

// File: tb/test_sbi_addr_gen.sv
module test_sbi_addr_gen;
  localparam int LW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [LW-1:0] fill_i = '0;
  logic [1:0]    sel_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [LW-1:0] out_index_o;
  logic          out_null_o;
  logic          done_o;

  int checks = 0;
  int bad = 0;

  int ptab [32] = '{0,16,8,24,4,20,12,28,2,18,10,26,6,22,14,30,
                    1,17,9,25,5,21,13,29,3,19,11,27,7,23,15,31};

  always #4 clk = ~clk;

  sbi_addr_gen i_sbi_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .fill_i(fill_i), .sel_i(sel_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_index_o(out_index_o),
    .out_null_o(out_null_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit ready_of(input int mode, input int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 3) != 0;
    return (cyc % 2) == 0;
  endfunction

  // d: length, f: fillers, s: selector, mode: ready pattern, poke: mid-run start
  task automatic run(input int d, input int f, input int s, input int mode, input bit poke);
    int r, nd, total, k, cyc, nulls, exp_nulls, held_idx, held_nul;
    bit holding;
    r = (d + 31) / 32;
    total = 32 * r;
    nd = total - d;
    exp_nulls = nd + ((s < 2) ? f : 0);
    @(negedge clk);
    len_i = LW'(d); fill_i = LW'(f); sel_i = 2'(s); start_i = 1'b1; out_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(out_valid_o == 1'b1, "R10 valid after start", int'(out_valid_o), 1);
    k = 0; cyc = 0; nulls = 0; holding = 1'b0; held_idx = 0; held_nul = 0;
    while (k < total) begin
      bit rdy;
      if (holding) begin
        chk(int'(out_index_o) == held_idx, "R8 held index", int'(out_index_o), held_idx);
        chk(int'(out_null_o) == held_nul, "R8 held null", int'(out_null_o), held_nul);
      end
      chk(out_valid_o == 1'b1 && done_o == 1'b0, "R2 valid during run",
          int'({out_valid_o, done_o}), 2);
      rdy = ready_of(mode, cyc);
      out_ready_i = rdy;
      if (poke && cyc == 5) begin
        start_i = 1'b1; len_i = LW'(200); sel_i = 2'(2 - (s % 2)); fill_i = '0;
      end else begin
        start_i = 1'b0;
      end
      if (rdy) begin
        int c, rw, p, enul, eidx;
        c = k / r; rw = k % r;
        p = ptab[c] + 32 * rw;               // R4
        if (s >= 2) p = (p + 1) % total;     // R5
        enul = (p < nd || (s < 2 && p - nd < f)) ? 1 : 0;  // R3 R6
        eidx = enul ? 0 : p - nd;            // R7
        nulls += enul;
        chk(int'(out_null_o) == enul, "R6 null flag", int'(out_null_o), enul);
        chk(int'(out_index_o) == eidx, "R7 index", int'(out_index_o), eidx);
        k++;
        holding = 1'b0;
      end else begin
        holding = 1'b1;
        held_idx = int'(out_index_o);
        held_nul = int'(out_null_o);
      end
      @(negedge clk);
      cyc++;
      if (cyc > 4 * total + 20) begin
        chk(1'b0, "R2 slot count", k, total);
        break;
      end
    end
    start_i = 1'b0;
    out_ready_i = 1'b0;
    chk(nulls == exp_nulls, "R3 null count", nulls, exp_nulls);
    chk(done_o == 1'b1, "R9 done after last", int'(done_o), 1);
    chk(out_valid_o == 1'b0, "R9 valid low at done", int'(out_valid_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", int'(done_o), 0);
    chk(out_valid_o == 1'b0, "R2 no extra slot", int'(out_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 reset valid", int'(out_valid_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    run(44, 0, 0, 0, 1'b0);
    run(44, 0, 1, 1, 1'b0);
    run(44, 0, 2, 2, 1'b0);
    run(92, 4, 0, 1, 1'b1);
    run(92, 4, 1, 0, 1'b0);
    run(92, 4, 2, 1, 1'b1);
    run(32, 0, 0, 2, 1'b0);
    run(32, 0, 3, 0, 1'b0);
    run(33, 0, 2, 0, 1'b0);
    run(33, 1, 1, 2, 1'b0);
    run(64, 0, 2, 1, 1'b0);
    run(6148, 0, 2, 1, 1'b0);
    run(6148, 24, 0, 0, 1'b0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule